// File: doc/BRIEF.md
# Carrier Sense and Collision Detector

This block generates the carrier-sense and collision indications that a PHY hands to the MAC across a media-independent interface. The 100 Mb/s receive path supplies one recovered bit per strobe. The 10 Mb/s path supplies an activity flag taken from the unsquelched receiver. The MAC's transmit enable and a small set of mode inputs complete the picture: speed, full or half duplex, repeater operation, and a switch that suppresses the post-transmit signal quality test.

At 100 Mb/s the block finds receive activity in the bit stream. Activity starts when the ten most recent bits hold two zeros with at least one bit between them. It lasts until ten ones in a row have been received. The active speed selects the receive activity source. The mode then decides whether transmit activity also raises carrier sense. A collision is flagged when transmission and reception overlap, except in full duplex.

In 10 Mb/s half duplex, a collision pulse of fixed length follows a fixed delay after each transmission. This is the signal quality test, and the inhibit input can suppress it. Mode inputs are captured only while the line is quiet, so a change never lands in the middle of a frame.

Top module: `crs_col_gen`

## Requirements
- R1: During and directly after a synchronous reset, `crs` and `col` are low.
- R2: In half duplex without repeater mode, `crs` is high one cycle after `tx_en` is high, or one cycle after the selected receive activity is present.
- R3: In full-duplex or repeater mode, `crs` follows only the selected receive activity, and `tx_en` alone leaves it low.
- R4: In half duplex, including repeater mode, `col` is high one cycle after `tx_en` and the selected receive activity are present together.
- R5: In full duplex, `col` stays low in every cycle, including after a transmission ends.
- R6: At 100 Mb/s, a bit is taken on every clock with `rx_bit_vld` high. Receive activity starts at such a bit when the last 10 bits taken, including the new one, hold two zeros that are at least two positions apart. `crs` rises two cycles after that bit is driven. Two neighbouring zeros alone do not start activity. Zeros 9 positions apart do start it, and zeros 10 positions apart do not.
- R7: Once 100 Mb/s activity has started, it lasts until 10 consecutive ones have been taken. A zero restarts that count. `crs` falls one cycle after the bit following the tenth one.
- R8: A bit presented with `rx_bit_vld` low is ignored.
- R9: At 100 Mb/s, `rx_act_10m` has no effect on the outputs. At 10 Mb/s, the bit stream has no effect on the outputs.
- R10: In 10 Mb/s half duplex with the inhibit low, let edge 0 be the first clock edge that sees `tx_en` low after it was high. `col` is then high after edges SQE_DELAY+1 through SQE_DELAY+SQE_WIDTH, and low after edges 0 through SQE_DELAY and after edge SQE_DELAY+SQE_WIDTH+1. `crs` stays low throughout.
- R11: No such pulse appears when `cfg_sqe_inhibit` is high at the end of transmission, or at 100 Mb/s.
- R12: Speed, duplex and repeater inputs are captured only in a cycle with no transmit activity, no receive activity on either path and no test pulse pending. A change made during activity takes effect only after the line goes quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit enable from the MAC |
| rx_bit_vld | input | 1 | Strobe marking a valid 100 Mb/s receive bit |
| rx_bit | input | 1 | 100 Mb/s receive bit |
| rx_act_10m | input | 1 | 10 Mb/s unsquelched receive activity |
| cfg_speed_100 | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| cfg_full_dup | input | 1 | 1 selects full duplex |
| cfg_repeater | input | 1 | 1 selects repeater operation |
| cfg_sqe_inhibit | input | 1 | 1 suppresses the post-transmit collision pulse |
| crs | output | 1 | Carrier sense, registered |
| col | output | 1 | Collision, registered |

## Verification
From `tx_en` or `rx_act_10m`, a result is due one cycle later, because only the output register lies in the path. From a 100 Mb/s bit, the activity flag and then the output register put the result two cycles later. The release is seen one bit after the tenth one. The collision pulse is timed from the first edge that sees `tx_en` low. The bench drives every input on a falling edge and samples on a later falling edge, after exactly the number of rising edges given above. Each check therefore lands on the cycle the requirement names, and the cycles just before and after that window are checked as well.

// File: rtl/crs_col_pkg.sv
package crs_col_pkg;

  typedef struct packed {
    logic spd100;
    logic fdx;
    logic rptr;
  } mode_t;

  typedef enum logic [1:0] {
    SQE_IDLE  = 2'd0,
    SQE_WAIT  = 2'd1,
    SQE_PULSE = 2'd2
  } sqe_state_t;

endpackage

// File: rtl/rx100_activity.sv
module rx100_activity #(
  parameter int WIN_BITS  = 10,
  parameter int IDLE_ONES = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  output logic active
);
  localparam int RUN_W = $clog2(IDLE_ONES + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(IDLE_ONES - 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(IDLE_ONES);

  logic [WIN_BITS-1:0] win_q;
  logic [WIN_BITS-1:0] win_nx;
  logic [RUN_W-1:0]    run_q;
  logic                spread_zeros;

  assign win_nx = {win_q[WIN_BITS-2:0], bit_in};

  // look for any pair of zeros with a gap of at least one bit
  always_comb begin
    spread_zeros = 1'b0;
    for (int i = 0; i < WIN_BITS - 2; i++) begin
      for (int j = i + 2; j < WIN_BITS; j++) begin
        spread_zeros = spread_zeros | (~win_nx[i] & ~win_nx[j]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '1;
      run_q  <= '0;
      active <= 1'b0;
    end else if (bit_vld) begin
      win_q <= win_nx;
      if (!bit_in)
        run_q <= '0;
      else if (run_q != RUN_MAX)
        run_q <= run_q + 1'b1;
      if (spread_zeros)
        active <= 1'b1;
      else if (bit_in && run_q == RUN_LAST)
        active <= 1'b0;
    end
  end

  // R6
  act_start_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> ($past(bit_vld) && !$past(bit_in)));

  // R7
  act_hold_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (active && bit_vld && !bit_in) |=> active);

  // R8
  act_stable_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(active));

endmodule

// File: rtl/sqe_timer.sv
module sqe_timer
  import crs_col_pkg::*;
#(
  parameter int SQE_DELAY = 8,
  parameter int SQE_WIDTH = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic arm,
  output logic pulse,
  output logic busy
);
  localparam int CNT_MAX = (SQE_DELAY > SQE_WIDTH) ? SQE_DELAY : SQE_WIDTH;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(SQE_DELAY - 1);
  localparam logic [CNT_W-1:0] WID_LAST = CNT_W'(SQE_WIDTH - 1);

  sqe_state_t       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tx_q;
  logic             tx_fall;

  assign tx_fall = tx_q & ~tx_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SQE_IDLE;
      cnt_q <= '0;
      tx_q  <= 1'b0;
    end else begin
      tx_q <= tx_en;
      if (tx_en) begin
        st_q  <= SQE_IDLE;
        cnt_q <= '0;
      end else if (tx_fall) begin
        st_q  <= arm ? SQE_WAIT : SQE_IDLE;
        cnt_q <= '0;
      end else begin
        case (st_q)
          SQE_WAIT: begin
            if (cnt_q == DLY_LAST) begin
              st_q  <= SQE_PULSE;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          SQE_PULSE: begin
            if (cnt_q == WID_LAST) begin
              st_q  <= SQE_IDLE;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: begin
            st_q  <= SQE_IDLE;
            cnt_q <= '0;
          end
        endcase
      end
    end
  end

  assign pulse = (st_q == SQE_PULSE);
  assign busy  = (st_q != SQE_IDLE);

  // R10
  sqe_after_tx_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> (!tx_en && !$past(tx_en)));

  // R11
  sqe_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_fall && !arm) |=> !busy);

endmodule

// File: rtl/mode_hold.sv
module mode_hold
  import crs_col_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  quiet,
  input  mode_t cfg_in,
  output mode_t mode_q
);
  always_ff @(posedge clk) begin
    if (rst || quiet)
      mode_q <= cfg_in;
  end

  // R12
  mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !quiet |=> $stable(mode_q));

endmodule

// File: rtl/crs_col_gen.sv
module crs_col_gen
  import crs_col_pkg::*;
#(
  parameter int WIN_BITS  = 10,
  parameter int IDLE_ONES = 10,
  parameter int SQE_DELAY = 8,
  parameter int SQE_WIDTH = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic rx_bit_vld,
  input  logic rx_bit,
  input  logic rx_act_10m,
  input  logic cfg_speed_100,
  input  logic cfg_full_dup,
  input  logic cfg_repeater,
  input  logic cfg_sqe_inhibit,
  output logic crs,
  output logic col
);
  mode_t mode_cfg;
  mode_t mode_q;
  logic  act100;
  logic  rx_act;
  logic  line_quiet;
  logic  sqe_arm;
  logic  sqe_on;
  logic  sqe_busy;
  logic  crs_d;
  logic  col_d;

  assign mode_cfg = '{spd100: cfg_speed_100, fdx: cfg_full_dup, rptr: cfg_repeater};

  rx100_activity #(
    .WIN_BITS (WIN_BITS),
    .IDLE_ONES(IDLE_ONES)
  ) u_rx100 (
    .clk    (clk),
    .rst    (rst),
    .bit_vld(rx_bit_vld),
    .bit_in (rx_bit),
    .active (act100)
  );

  assign line_quiet = ~tx_en & ~act100 & ~rx_act_10m & ~sqe_busy;

  mode_hold u_mode (
    .clk   (clk),
    .rst   (rst),
    .quiet (line_quiet),
    .cfg_in(mode_cfg),
    .mode_q(mode_q)
  );

  assign sqe_arm = ~mode_q.spd100 & ~mode_q.fdx & ~cfg_sqe_inhibit;

  sqe_timer #(
    .SQE_DELAY(SQE_DELAY),
    .SQE_WIDTH(SQE_WIDTH)
  ) u_sqe (
    .clk  (clk),
    .rst  (rst),
    .tx_en(tx_en),
    .arm  (sqe_arm),
    .pulse(sqe_on),
    .busy (sqe_busy)
  );

  assign rx_act = mode_q.spd100 ? act100 : rx_act_10m;
  assign crs_d  = rx_act | (tx_en & ~mode_q.fdx & ~mode_q.rptr);
  assign col_d  = ~mode_q.fdx & ((rx_act & tx_en) | sqe_on);

  always_ff @(posedge clk) begin
    if (rst) begin
      crs <= 1'b0;
      col <= 1'b0;
    end else begin
      crs <= crs_d;
      col <= col_d;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!crs && !col));

  // R2
  half_tx_crs_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && !mode_q.fdx && !mode_q.rptr) |=> crs);

  // R3
  crs_rx_only_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_q.fdx || mode_q.rptr) && !rx_act) |=> !crs);

  // R4
  col_on_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && rx_act && !mode_q.fdx) |=> col);

  // R5
  fdx_col_low_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q.fdx |=> !col);

endmodule

// File: tb/tb_crs_col_gen.sv
module tb_crs_col_gen;
  localparam int DLY = 8;
  localparam int WID = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0;
  logic rx_bit_vld = 1'b0;
  logic rx_bit = 1'b1;
  logic rx_act_10m = 1'b0;
  logic cfg_speed_100 = 1'b0;
  logic cfg_full_dup = 1'b0;
  logic cfg_repeater = 1'b0;
  logic cfg_sqe_inhibit = 1'b1;
  logic crs;
  logic col;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  crs_col_gen #(
    .WIN_BITS (10),
    .IDLE_ONES(10),
    .SQE_DELAY(DLY),
    .SQE_WIDTH(WID)
  ) dut (
    .clk            (clk),
    .rst            (rst),
    .tx_en          (tx_en),
    .rx_bit_vld     (rx_bit_vld),
    .rx_bit         (rx_bit),
    .rx_act_10m     (rx_act_10m),
    .cfg_speed_100  (cfg_speed_100),
    .cfg_full_dup   (cfg_full_dup),
    .cfg_repeater   (cfg_repeater),
    .cfg_sqe_inhibit(cfg_sqe_inhibit),
    .crs            (crs),
    .col            (col)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic set_mode(input logic s100, input logic fd, input logic rp, input logic inh);
    cfg_speed_100   = s100;
    cfg_full_dup    = fd;
    cfg_repeater    = rp;
    cfg_sqe_inhibit = inh;
    cyc(2);
  endtask

  task automatic send_bit(input logic b);
    rx_bit_vld = 1'b1;
    rx_bit     = b;
    cyc(1);
  endtask

  task automatic send_ones(input int n);
    for (int k = 0; k < n; k++) send_bit(1'b1);
  endtask

  // R1
  task automatic t_reset;
    rst = 1'b1;
    cyc(3);
    chk("R1", "crs in reset", crs, 1'b0);
    chk("R1", "col in reset", col, 1'b0);
    rst = 1'b0;
    cyc(1);
    chk("R1", "crs after reset", crs, 1'b0);
    chk("R1", "col after reset", col, 1'b0);
  endtask

  task automatic t_half10;
    set_mode(1'b0, 1'b0, 1'b0, 1'b1);
    tx_en = 1'b1; cyc(1);
    chk("R2", "crs on tx", crs, 1'b1);
    chk("R4", "col tx only", col, 1'b0);
    rx_act_10m = 1'b1; cyc(1);
    chk("R4", "col on overlap", col, 1'b1);
    tx_en = 1'b0; cyc(1);
    chk("R2", "crs on rx", crs, 1'b1);
    chk("R4", "col rx only", col, 1'b0);
    rx_act_10m = 1'b0; cyc(1);
    chk("R2", "crs idle", crs, 1'b0);
    cyc(2);
  endtask

  task automatic t_full10;
    logic seen;
    set_mode(1'b0, 1'b1, 1'b0, 1'b0);
    tx_en = 1'b1; cyc(1);
    chk("R3", "crs tx in full dup", crs, 1'b0);
    rx_act_10m = 1'b1; cyc(1);
    chk("R3", "crs rx in full dup", crs, 1'b1);
    chk("R5", "col overlap full dup", col, 1'b0);
    tx_en = 1'b0; rx_act_10m = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < DLY + WID + 3; k++) begin
      cyc(1);
      seen = seen | col;
    end
    chk("R5", "col after tx full dup", seen, 1'b0);
  endtask

  task automatic t_rep10;
    set_mode(1'b0, 1'b0, 1'b1, 1'b1);
    tx_en = 1'b1; cyc(1);
    chk("R3", "crs tx repeater", crs, 1'b0);
    rx_act_10m = 1'b1; cyc(1);
    chk("R4", "col repeater overlap", col, 1'b1);
    chk("R3", "crs rx repeater", crs, 1'b1);
    tx_en = 1'b0; rx_act_10m = 1'b0; cyc(3);
  endtask

  // R10
  task automatic t_sqe;
    logic early;
    set_mode(1'b0, 1'b0, 1'b0, 1'b0);
    tx_en = 1'b1; cyc(3);
    tx_en = 1'b0;
    early = 1'b0;
    for (int k = 0; k < DLY + 1; k++) begin
      cyc(1);
      early = early | col;
    end
    chk("R10", "col before pulse", early, 1'b0);
    for (int k = 0; k < WID; k++) begin
      cyc(1);
      chk("R10", "col in pulse", col, 1'b1);
      chk("R10", "crs in pulse", crs, 1'b0);
    end
    cyc(1);
    chk("R10", "col after pulse", col, 1'b0);
    cyc(2);
  endtask

  // R11
  task automatic t_no_sqe(input logic s100, input logic inh, input string what);
    logic seen;
    set_mode(s100, 1'b0, 1'b0, inh);
    rx_bit_vld = s100; rx_bit = 1'b1;
    tx_en = 1'b1; cyc(3);
    tx_en = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < DLY + WID + 3; k++) begin
      cyc(1);
      seen = seen | col;
    end
    chk("R11", what, seen, 1'b0);
    rx_bit_vld = 1'b0;
  endtask

  task automatic t_100m;
    logic seen;
    set_mode(1'b1, 1'b0, 1'b0, 1'b1);
    send_ones(12);
    // R6 neighbouring zeros only
    send_bit(1'b0); send_bit(1'b0);
    seen = 1'b0;
    for (int k = 0; k < 12; k++) begin
      send_bit(1'b1);
      seen = seen | crs;
    end
    chk("R6", "adjacent zeros", seen, 1'b0);
    // R6 zeros one apart, then R7 hold and release
    send_bit(1'b0); send_bit(1'b1);
    chk("R6", "crs before second zero", crs, 1'b0);
    send_bit(1'b0); send_bit(1'b1);
    chk("R6", "crs after gap zero", crs, 1'b1);
    send_ones(4); send_bit(1'b0); send_ones(9);
    chk("R7", "held after restarted run", crs, 1'b1);
    send_bit(1'b1);
    chk("R7", "held at tenth one", crs, 1'b1);
    send_bit(1'b1);
    chk("R7", "released after ten ones", crs, 1'b0);
    // R6 distance nine
    send_ones(2);
    send_bit(1'b0); send_ones(8);
    chk("R6", "single zero only", crs, 1'b0);
    send_bit(1'b0); send_bit(1'b1);
    chk("R6", "zeros nine apart", crs, 1'b1);
    send_ones(10);
    chk("R7", "release after distance nine", crs, 1'b0);
    // R6 distance ten
    send_bit(1'b0); send_ones(9); send_bit(1'b0);
    seen = 1'b0;
    for (int k = 0; k < 12; k++) begin
      send_bit(1'b1);
      seen = seen | crs;
    end
    chk("R6", "zeros ten apart", seen, 1'b0);
    // R8 strobe low
    rx_bit_vld = 1'b0; rx_bit = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 6; k++) begin
      cyc(1);
      seen = seen | crs;
    end
    send_bit(1'b1); send_bit(1'b1);
    seen = seen | crs;
    chk("R8", "bits without strobe", seen, 1'b0);
    // R4 at 100 Mb/s
    tx_en = 1'b1;
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    chk("R4", "col overlap 100M", col, 1'b1);
    tx_en = 1'b0;
    send_ones(12);
    // R9 10M flag ignored at 100M
    rx_act_10m = 1'b1; send_bit(1'b1); send_bit(1'b1);
    chk("R9", "10M flag at 100M", crs, 1'b0);
    rx_act_10m = 1'b0; send_ones(2);
    rx_bit_vld = 1'b0;
  endtask

  // R9 bit stream ignored at 10M
  task automatic t_stream_at_10m;
    logic seen;
    set_mode(1'b0, 1'b0, 1'b0, 1'b1);
    seen = 1'b0;
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    for (int k = 0; k < 12; k++) begin
      send_bit(1'b1);
      seen = seen | crs;
    end
    chk("R9", "stream at 10M", seen, 1'b0);
    rx_bit_vld = 1'b0;
  endtask

  // R12
  task automatic t_mode_change;
    set_mode(1'b0, 1'b0, 1'b0, 1'b1);
    tx_en = 1'b1; cyc(1);
    cfg_full_dup = 1'b1; cyc(3);
    chk("R12", "mode held during tx", crs, 1'b1);
    tx_en = 1'b0; cyc(2);
    tx_en = 1'b1; cyc(1);
    chk("R12", "mode taken when quiet", crs, 1'b0);
    tx_en = 1'b0; cyc(2);
  endtask

  initial begin
    #400us;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(1);
    t_reset();
    t_half10();
    t_full10();
    t_rep10();
    t_sqe();
    t_no_sqe(1'b0, 1'b1, "inhibited pulse");
    t_no_sqe(1'b1, 1'b0, "pulse at 100M");
    t_100m();
    t_stream_at_10m();
    t_mode_change();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule